// File: doc/BRIEF.md
# Vertical blank event sequencer

This block times the vertical part of an interlaced video field by counting clock cycles. Software supplies the number of cycles in one scanline, a standard select (NTSC or PAL) and the number of cycles in a full two-field frame. From these the block derives the length of the active (render) part of each field, the length of the vertical blank, and the point inside the blank where a delayed event fires. It emits a one-cycle pulse when the blank begins and another when it ends.

The field-parity bit does not flip at the start of the blank. It flips at a later event, three and a half scanlines into the blank. That same event sets a sticky vertical-sync status bit and may raise an interrupt. The blank still ends a fixed number of scanlines after it began, so the delayed event does not stretch it. Software clears the status bit with a write-one-to-clear strobe and controls a mask bit that gates the interrupt request.

Top module: `vblank_seq`

## Requirements
- R1: After a synchronous reset, `mode` is 0, `fieldBit` is 0, `syncStatus` is 0, `irqReq`, `vblankStart` and `vblankEnd` are 0, and the interrupt mask is set.
- R2: The blank lasts B cycles, where B = `lineCycles` × 26 when `palMode` is 0 and `lineCycles` × 22 when `palMode` is 1. `vblankEnd` pulses B cycles after `vblankStart`.
- R3: The render interval lasts R = floor(`frameCycles` / 2) − B cycles. `vblankStart` pulses R cycles after reset release or after a `vblankEnd` pulse.
- R4: `mode` reads 0 during render, 2 from blank start until the delayed event, and 3 from the delayed event until blank end. It only steps 0→2→3→0, and value 1 never appears.
- R5: The delayed event occurs D = floor(7 × `lineCycles` / 2) cycles after the blank starts, which is 3.5 scanlines counted in half-scanline units. At that event `fieldBit` toggles.
- R6: `fieldBit` changes at no other time. In particular it does not change at blank start or at blank end.
- R7: At the delayed event `syncStatus` becomes 1. `irqReq` is a one-cycle pulse in the cycle `syncStatus` goes from 0 to 1, and only if the mask was clear. If the status bit was already set, no pulse is produced.
- R8: A one-cycle `statusClr` strobe clears `syncStatus` in the following cycle. A clear that coincides with the delayed event leaves the bit set.
- R9: A `maskWr` strobe loads `maskWrData` into the mask. While the mask is 1, the delayed event raises no `irqReq`.
- R10: `vblankStart` and `vblankEnd` are each high for exactly one cycle per field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lineCycles | input | LINE_W | Clock cycles per scanline |
| palMode | input | 1 | 0 selects 26 blank lines, 1 selects 22 |
| frameCycles | input | FRAME_W | Clock cycles per full two-field frame |
| statusClr | input | 1 | Write-one-to-clear strobe for the sync status bit |
| maskWr | input | 1 | Load strobe for the interrupt mask |
| maskWrData | input | 1 | Value loaded into the mask |
| mode | output | 2 | Sequencer state: 0 render, 2 swap wait, 3 sync wait |
| vblankStart | output | 1 | One-cycle pulse at blank start |
| vblankEnd | output | 1 | One-cycle pulse at blank end |
| fieldBit | output | 1 | Field parity, toggled at the delayed event |
| syncStatus | output | 1 | Sticky vertical-sync status |
| irqReq | output | 1 | Masked interrupt request pulse |

## Verification
The assertions check these properties on every cycle:
- the legal state encodings and the 0→2→3→0 stepping;
- that both blank pulses last one cycle and line up with the matching mode transitions;
- that `fieldBit` moves only on the 2→3 step;
- that `irqReq` appears only on a clear-to-set change of the status bit with the mask clear;
- that the status bit falls only after a clear strobe.

The exact cycle counts R, B and D are data-dependent, so only the bench's scenarios can confirm them. The bench runs them over several line lengths, both standards and an odd line length that exercises the half-scanline rounding. The bench also covers the mask and clear sequences, including a clear that lands on the set event.

// File: rtl/vblank_seq_pkg.sv
package vblank_seq_pkg;

  // Sequencer state; the numeric codes are visible on the mode port.
  typedef enum logic [1:0] {
    VM_RENDER    = 2'd0,
    VM_SPARE     = 2'd1,
    VM_SWAP_WAIT = 2'd2,
    VM_SYNC_WAIT = 2'd3
  } vMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic cntClear;
    logic startFire;
    logic swapFire;
    logic endFire;
  } seqStrobe_t;

  // Interval-complete flags from datapath to control.
  typedef struct packed {
    logic renderDone;
    logic swapDue;
    logic blankDone;
  } seqFlags_t;

endpackage

// File: rtl/vblank_seq_ctrl.sv
module vblank_seq_ctrl
  import vblank_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seqFlags_t  flags,
  output seqStrobe_t strobe,
  output vMode_e     mode
);

  vMode_e modeQ;
  vMode_e modeD;

  always_comb begin
    modeD  = modeQ;
    strobe = '0;
    case (modeQ)
      VM_RENDER: begin
        if (flags.renderDone) begin
          modeD            = VM_SWAP_WAIT;
          strobe.cntClear  = 1'b1;
          strobe.startFire = 1'b1;
        end
      end
      VM_SWAP_WAIT: begin
        // The counter keeps running: the blank end stays timed from blank start.
        if (flags.swapDue) begin
          modeD           = VM_SYNC_WAIT;
          strobe.swapFire = 1'b1;
        end
      end
      VM_SYNC_WAIT: begin
        if (flags.blankDone) begin
          modeD           = VM_RENDER;
          strobe.cntClear = 1'b1;
          strobe.endFire  = 1'b1;
        end
      end
      default: begin
        modeD           = VM_RENDER;
        strobe.cntClear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) modeQ <= VM_RENDER;
    else     modeQ <= modeD;
  end

  assign mode = modeQ;

endmodule

// File: rtl/vblank_seq_dp.sv
module vblank_seq_dp
  import vblank_seq_pkg::*;
#(
  parameter int LINE_W       = 12,
  parameter int FRAME_W      = 20,
  parameter int NTSC_LINES   = 26,
  parameter int PAL_LINES    = 22,
  parameter int DELAY_HALVES = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LINE_W-1:0]  lineCycles,
  input  logic               palMode,
  input  logic [FRAME_W-1:0] frameCycles,
  input  seqStrobe_t         strobe,
  input  logic               statusClr,
  input  logic               maskWr,
  input  logic               maskWrData,
  output seqFlags_t          flags,
  output logic               vblankStart,
  output logic               vblankEnd,
  output logic               fieldBit,
  output logic               syncStatus,
  output logic               irqReq,
  output logic               maskBit
);

  localparam int MUL_W = LINE_W + 6;
  localparam int CNT_W = FRAME_W;
  localparam int CMP_W = ((FRAME_W > MUL_W) ? FRAME_W : MUL_W) + 1;
  localparam logic [CMP_W-1:0] CMP_ONE = CMP_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // Interval lengths
  logic [MUL_W-1:0]   lineCount;
  logic [MUL_W-1:0]   blankLen;
  logic [MUL_W-1:0]   swapHalves;
  logic [MUL_W-1:0]   swapLen;
  logic [FRAME_W-1:0] halfFrame;
  logic [CMP_W-1:0]   renderLen;

  assign lineCount  = palMode ? MUL_W'(PAL_LINES) : MUL_W'(NTSC_LINES);
  assign blankLen   = MUL_W'(lineCycles) * lineCount;
  // Delay counted in half scanlines, then halved once: integer only.
  assign swapHalves = MUL_W'(lineCycles) * MUL_W'(DELAY_HALVES);
  assign swapLen    = swapHalves >> 1;
  assign halfFrame  = frameCycles >> 1;
  assign renderLen  = CMP_W'(halfFrame) - CMP_W'(blankLen);

  // Cycle counter
  logic [CNT_W-1:0] cntQ;
  logic [CMP_W-1:0] cntNext;

  assign cntNext = CMP_W'(cntQ) + CMP_ONE;

  always_ff @(posedge clk) begin
    if (rst || strobe.cntClear) cntQ <= '0;
    else                        cntQ <= cntQ + CNT_ONE;
  end

  assign flags.renderDone = (cntNext >= renderLen);
  assign flags.swapDue    = (cntNext >= CMP_W'(swapLen));
  assign flags.blankDone  = (cntNext >= CMP_W'(blankLen));

  // Boundary pulses
  logic startQ;
  logic endQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      startQ <= 1'b0;
      endQ   <= 1'b0;
    end else begin
      startQ <= strobe.startFire;
      endQ   <= strobe.endFire;
    end
  end

  assign vblankStart = startQ;
  assign vblankEnd   = endQ;

  // Field, status, mask, interrupt
  logic fieldQ;
  logic statusQ;
  logic maskQ;
  logic irqQ;

  always_ff @(posedge clk) begin
    if (rst) fieldQ <= 1'b0;
    else if (strobe.swapFire) fieldQ <= ~fieldQ;
  end

  always_ff @(posedge clk) begin
    if (rst)                   statusQ <= 1'b0;
    else if (strobe.swapFire)  statusQ <= 1'b1;   // set wins over clear
    else if (statusClr)        statusQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)         maskQ <= 1'b1;
    else if (maskWr) maskQ <= maskWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) irqQ <= 1'b0;
    else     irqQ <= strobe.swapFire & ~statusQ & ~maskQ;
  end

  assign fieldBit   = fieldQ;
  assign syncStatus = statusQ;
  assign irqReq     = irqQ;
  assign maskBit    = maskQ;

endmodule

// File: rtl/vblank_seq.sv
module vblank_seq
  import vblank_seq_pkg::*;
#(
  parameter int LINE_W  = 12,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LINE_W-1:0]  lineCycles,
  input  logic               palMode,
  input  logic [FRAME_W-1:0] frameCycles,
  input  logic               statusClr,
  input  logic               maskWr,
  input  logic               maskWrData,
  output logic [1:0]         mode,
  output logic               vblankStart,
  output logic               vblankEnd,
  output logic               fieldBit,
  output logic               syncStatus,
  output logic               irqReq
);

  seqStrobe_t strobe;
  seqFlags_t  flags;
  vMode_e     modeState;
  logic       maskBit;

  vblank_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .flags  (flags),
    .strobe (strobe),
    .mode   (modeState)
  );

  vblank_seq_dp #(
    .LINE_W  (LINE_W),
    .FRAME_W (FRAME_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .lineCycles  (lineCycles),
    .palMode     (palMode),
    .frameCycles (frameCycles),
    .strobe      (strobe),
    .statusClr   (statusClr),
    .maskWr      (maskWr),
    .maskWrData  (maskWrData),
    .flags       (flags),
    .vblankStart (vblankStart),
    .vblankEnd   (vblankEnd),
    .fieldBit    (fieldBit),
    .syncStatus  (syncStatus),
    .irqReq      (irqReq),
    .maskBit     (maskBit)
  );

  assign mode = modeState;

endmodule

// File: rtl/vblank_seq_chk.sv
module vblank_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       vblankStart,
  input logic       vblankEnd,
  input logic       fieldBit,
  input logic       syncStatus,
  input logic       irqReq,
  input logic       statusClr,
  input logic       maskBit
);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd1); // R4

  AST_FROM_RENDER: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> (mode == 2'd0 || mode == 2'd2)); // R4

  AST_FROM_SWAP_WAIT: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2) |=> (mode == 2'd2 || mode == 2'd3)); // R4

  AST_FROM_SYNC_WAIT: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3) |=> (mode == 2'd3 || mode == 2'd0)); // R4

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    vblankStart |=> !vblankStart); // R10

  AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
    vblankEnd |=> !vblankEnd); // R10

  AST_START_ALIGN: assert property (@(posedge clk) disable iff (rst)
    vblankStart |-> (mode == 2'd2 && $past(mode) == 2'd0)); // R3

  AST_END_ALIGN: assert property (@(posedge clk) disable iff (rst)
    vblankEnd |-> (mode == 2'd0 && $past(mode) == 2'd3)); // R2

  AST_FIELD_AT_SWAP: assert property (@(posedge clk) disable iff (rst)
    (fieldBit != $past(fieldBit)) |-> (mode == 2'd3 && $past(mode) == 2'd2)); // R6

  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> (syncStatus && !$past(syncStatus) && !$past(maskBit))); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(syncStatus) && !syncStatus) |-> $past(statusClr)); // R8

endmodule

bind vblank_seq vblank_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode        (mode),
  .vblankStart (vblankStart),
  .vblankEnd   (vblankEnd),
  .fieldBit    (fieldBit),
  .syncStatus  (syncStatus),
  .irqReq      (irqReq),
  .statusClr   (statusClr),
  .maskBit     (maskBit)
);

// File: tb/vblank_seq_bench.sv
`timescale 1ns/1ps
module vblank_seq_bench;

  localparam int LINE_W  = 12;
  localparam int FRAME_W = 20;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [LINE_W-1:0]  lineCycles = '0;
  logic               palMode = 1'b0;
  logic [FRAME_W-1:0] frameCycles = '0;
  logic               statusClr = 1'b0;
  logic               maskWr = 1'b0;
  logic               maskWrData = 1'b0;
  logic [1:0]         mode;
  logic               vblankStart, vblankEnd, fieldBit, syncStatus, irqReq;

  always #4 clk = ~clk;  // 125 MHz

  vblank_seq #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_vblank_seq (
    .clk (clk), .rst (rst), .lineCycles (lineCycles), .palMode (palMode),
    .frameCycles (frameCycles), .statusClr (statusClr), .maskWr (maskWr),
    .maskWrData (maskWrData), .mode (mode), .vblankStart (vblankStart),
    .vblankEnd (vblankEnd), .fieldBit (fieldBit), .syncStatus (syncStatus),
    .irqReq (irqReq)
  );

  // Stimulus table: line, pal, frame, expected R, D, B (hand computed).
  typedef struct packed {
    int line; int pal; int frame; int r; int d; int b;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{10, 0, 1000, 240, 35, 260},
    '{10, 1, 1000, 280, 35, 220},
    '{ 9, 0, 1000, 266, 31, 234},
    '{ 7, 1,  800, 246, 24, 154}
  };

  int edges = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, edges, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    while (edges < n) @(negedge clk);
  endtask

  task automatic doReset(input int line, input int pal, input int frame);
    @(negedge clk);
    rst = 1'b1;
    lineCycles  = LINE_W'(line);
    palMode     = (pal != 0);
    frameCycles = FRAME_W'(frame);
    statusClr = 1'b0; maskWr = 1'b0; maskWrData = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // Table-driven pass over configurations
    for (int i = 0; i < 4; i++) begin
      vec_t v;
      v = VEC[i];
      doReset(v.line, v.pal, v.frame);
      waitEdges(v.r - 1);
      check("R3 render before start", int'(vblankStart), 0);
      check("R4 mode during render", int'(mode), 0);
      waitEdges(v.r);
      check("R3 start pulse", int'(vblankStart), 1);
      check("R4 mode at start", int'(mode), 2);
      check("R6 field at start", int'(fieldBit), 0);
      waitEdges(v.r + 1);
      check("R10 start width", int'(vblankStart), 0);
      waitEdges(v.r + v.d - 1);
      check("R5 field before event", int'(fieldBit), 0);
      check("R4 mode before event", int'(mode), 2);
      waitEdges(v.r + v.d);
      check("R5 field toggled", int'(fieldBit), 1);
      check("R4 mode after event", int'(mode), 3);
      check("R7 status set", int'(syncStatus), 1);
      check("R9 masked by default", int'(irqReq), 0);
      waitEdges(v.r + v.b - 1);
      check("R2 no end yet", int'(vblankEnd), 0);
      waitEdges(v.r + v.b);
      check("R2 end pulse", int'(vblankEnd), 1);
      check("R4 mode back to render", int'(mode), 0);
      check("R6 field at end", int'(fieldBit), 1);
      waitEdges(v.r + v.b + 1);
      check("R10 end width", int'(vblankEnd), 0);
      waitEdges(2 * v.r + v.b);
      check("R3 second start", int'(vblankStart), 1);
      waitEdges(2 * v.r + v.b + v.d);
      check("R5 field toggled back", int'(fieldBit), 0);
      check("R7 no irq when already set", int'(irqReq), 0);
    end

    // Directed: reset state, mask, clear, coincident clear (R=240 D=35 B=260)
    doReset(10, 0, 1000);
    check("R1 mode", int'(mode), 0);
    check("R1 field", int'(fieldBit), 0);
    check("R1 status", int'(syncStatus), 0);
    check("R1 irq", int'(irqReq), 0);
    check("R1 start", int'(vblankStart), 0);
    check("R1 end", int'(vblankEnd), 0);

    waitEdges(5);  maskWr = 1'b1; maskWrData = 1'b0;
    waitEdges(6);  maskWr = 1'b0;
    waitEdges(275);
    check("R7 irq on rise", int'(irqReq), 1);
    check("R7 status", int'(syncStatus), 1);
    waitEdges(276);
    check("R7 irq pulse width", int'(irqReq), 0);
    waitEdges(775);
    check("R7 no irq while set", int'(irqReq), 0);
    waitEdges(800); statusClr = 1'b1;
    waitEdges(801); statusClr = 1'b0;
    check("R8 clear", int'(syncStatus), 0);
    waitEdges(1274); statusClr = 1'b1;
    waitEdges(1275); statusClr = 1'b0;
    check("R8 set beats clear", int'(syncStatus), 1);
    check("R7 irq after clear", int'(irqReq), 1);
    waitEdges(1300); maskWr = 1'b1; maskWrData = 1'b1;
    waitEdges(1301); maskWr = 1'b0;
    waitEdges(1400); statusClr = 1'b1;
    waitEdges(1401); statusClr = 1'b0;
    check("R8 clear again", int'(syncStatus), 0);
    waitEdges(1775);
    check("R9 status set under mask", int'(syncStatus), 1);
    check("R9 mask blocks irq", int'(irqReq), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule